// File: doc/BRIEF.md
# Linearized Track Parameter Fitter

This block turns the fine coordinates of one candidate track into fitted parameters without any iterative helix fit. Each candidate has six signed coordinates: the curvature and azimuth of the outer track, followed by the hit positions on four silicon layers. Each output is an affine function of these six coordinates. The weights and the offset of every function are held in a constant store. The store has several banks, one for each angular sector of the detector, because a linear model is only accurate over a narrow region. A bank-select input arrives with each candidate and chooses which bank is used.

For every candidate the fitter evaluates six rows. Rows 0 to 2 give the curvature, azimuth and impact parameter. Rows 3 to 5 are residual constraints, and the squares of these three values are summed into a fit-quality figure. A single multiplier steps through every coefficient of every row, so a result appears a fixed number of cycles after the candidate is accepted. While that work is in progress the fitter takes no new candidate. Before any candidate arrives, software writes the constants one entry per cycle through a simple write port.

Top module: `lin_track_fit`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, `out_valid` is 0, and all result outputs and `out_ovf` are 0.
- R2: A candidate is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the results are presented. While it is 0, `in_valid`, `in_coord` and `in_set` have no effect on any output.
- R3: `out_valid` is a one-cycle pulse. It is high exactly N_ROW*N_IN (36) cycles after the accepting edge, and `in_ready` is 1 in that same cycle.
- R4: Row i of bank b gives S = off[b][i] + sum over j of V[b][i][j]*x[j]. Here x[j] is the signed 16-bit lane j of `in_coord` (bits 16j+15..16j): lane 0 is curvature, lane 1 is azimuth, lanes 2 to 5 are the silicon hits. The row value is floor(S / 2^FRAC) with FRAC = 8. Rows 0, 1 and 2 drive `out_curv`, `out_phi` and `out_d0`.
- R5: `out_chi2` is the unsigned sum of the squares of the saturated values of rows 3, 4 and 5.
- R6: Every row value is clipped to the range -32768..32767. `out_ovf` is 1 for a candidate when any of its six rows was clipped, and 0 otherwise.
- R7: The bank used for a candidate is the value of `in_set` on its accepting edge. Identical coordinates in different banks give the results of each bank's own constants.
- R8: A write with `cfg_we` = 1 stores `cfg_data` (signed 18-bit) at bank `cfg_set`, row `cfg_row`, column `cfg_col`. Columns 0 to 5 are the weights for lanes 0 to 5, and column 6 is the row offset. The new value is used by candidates accepted later.
- R9: Between `out_valid` pulses, every result output and `out_ovf` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Candidate offered |
| in_ready | output | 1 | Fitter idle, a candidate can be accepted |
| in_set | input | 2 | Constant bank for the candidate |
| in_coord | input | 96 | Six signed 16-bit coordinates, lane j at bits 16j+15..16j |
| cfg_we | input | 1 | Constant write strobe |
| cfg_set | input | 2 | Bank of the written constant |
| cfg_row | input | 3 | Row of the written constant (0..5) |
| cfg_col | input | 3 | Column: 0..5 weight, 6 offset |
| cfg_data | input | 18 | Signed constant value |
| out_valid | output | 1 | One-cycle result strobe |
| out_curv | output | 16 | Fitted curvature, signed |
| out_phi | output | 16 | Fitted azimuth, signed |
| out_d0 | output | 16 | Fitted impact parameter, signed |
| out_chi2 | output | 34 | Sum of squared residuals, unsigned |
| out_ovf | output | 1 | At least one row was clipped |

## Verification
The bench drives candidates whose sums overflow the 16-bit output range in both directions. A fitter that truncates instead of clipping would return wrapped values with the wrong sign, and one that ignores the residual rows would leave the overflow flag low. The bench holds `in_valid` high with new coordinates and a new bank while the fitter is busy. A fitter that re-accepts in that state would either move its result strobe or fit the wrong coordinates. The bench sends the same coordinates to two banks, and it rewrites a single weight between two candidates. A fitter that latched the bank at the wrong time, or read stale constants, would repeat the earlier result. A fitter that cleared the chi-square accumulator at the wrong point would carry the previous candidate's residuals into the next one.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fit_state_e;
endpackage

// File: rtl/fit_coef_store.sv
module fit_coef_store #(
  parameter int N_SET = 4,
  parameter int N_ROW = 6,
  parameter int N_COL = 7,
  parameter int CW    = 18,
  parameter int SW    = 2,
  parameter int RW    = 3,
  parameter int CLW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SW-1:0]        wr_set,
  input  logic [RW-1:0]        wr_row,
  input  logic [CLW-1:0]       wr_col,
  input  logic signed [CW-1:0] wr_data,
  input  logic [SW-1:0]        rd_set,
  input  logic [RW-1:0]        rd_row,
  input  logic [CLW-1:0]       rd_col,
  output logic signed [CW-1:0] rd_coef,
  output logic signed [CW-1:0] rd_off
);
  localparam int DEPTH = N_SET * N_ROW * N_COL;
  localparam int MAW   = $clog2(DEPTH);

  logic signed [CW-1:0] mem [DEPTH];

  function automatic logic [MAW-1:0] flat_addr(input logic [SW-1:0] s,
                                               input logic [RW-1:0] r,
                                               input logic [CLW-1:0] c);
    int a;
    a = (int'(s) * N_ROW + int'(r)) * N_COL + int'(c);
    return MAW'(a);
  endfunction

  logic wr_ok;
  assign wr_ok = we && (int'(wr_row) < N_ROW) && (int'(wr_col) < N_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_ok) begin
      mem[flat_addr(wr_set, wr_row, wr_col)] <= wr_data;
    end
  end

  assign rd_coef = mem[flat_addr(rd_set, rd_row, rd_col)];
  assign rd_off  = mem[flat_addr(rd_set, rd_row, CLW'(N_COL - 1))];
endmodule

// File: rtl/fit_sequencer.sv
module fit_sequencer
  import fit_pkg::*;
#(
  parameter int N_ROW = 6,
  parameter int N_IN  = 6,
  parameter int RW    = 3,
  parameter int CLW   = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           busy,
  output logic           first_col,
  output logic           row_done,
  output logic           cand_done,
  output logic [RW-1:0]  row_idx,
  output logic [CLW-1:0] col_idx
);
  fit_state_e st;
  logic last_col, last_row;

  assign last_col  = (col_idx == CLW'(N_IN - 1));
  assign last_row  = (row_idx == RW'(N_ROW - 1));
  assign busy      = (st == ST_RUN);
  assign first_col = busy && (col_idx == '0);
  assign row_done  = busy && last_col;
  assign cand_done = row_done && last_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      row_idx <= '0;
      col_idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_RUN;
          row_idx <= '0;
          col_idx <= '0;
        end
        ST_RUN: if (last_col) begin
          col_idx <= '0;
          if (last_row) st <= ST_IDLE;
          else          row_idx <= row_idx + 1'b1;
        end else begin
          col_idx <= col_idx + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fit_mac.sv
module fit_mac #(
  parameter int DW   = 16,
  parameter int CW   = 18,
  parameter int AW   = 44,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 first,
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] coef,
  input  logic signed [CW-1:0] offset,
  output logic signed [DW-1:0] res,
  output logic                 res_clip
);
  localparam logic signed [AW-1:0] MAXV = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = AW'(-(2 ** (DW - 1)));

  // Scale down by 2^FRAC (floor) and clip to DW bits; MSB of result is clip flag.
  function automatic logic [DW:0] scale_clip(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] s;
    s = v >>> FRAC;
    if (s > MAXV)      return {1'b1, MAXV[DW-1:0]};
    else if (s < MINV) return {1'b1, MINV[DW-1:0]};
    else               return {1'b0, s[DW-1:0]};
  endfunction

  logic signed [DW+CW-1:0] prod_raw;
  logic signed [AW-1:0]    prod, base, sum, acc;
  logic [DW:0]             packed_res;

  assign prod_raw   = x * coef;
  assign prod       = AW'(prod_raw);
  assign base       = first ? AW'(offset) : acc;
  assign sum        = base + prod;
  assign packed_res = scale_clip(sum);
  assign res        = packed_res[DW-1:0];
  assign res_clip   = packed_res[DW];

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (step) acc <= sum;
  end
endmodule

// File: rtl/lin_track_fit.sv
module lin_track_fit #(
  parameter int N_IN  = 6,
  parameter int N_RES = 3,
  parameter int N_SET = 4,
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int AW    = 44,
  parameter int FRAC  = 8,
  localparam int N_PAR = 3,
  localparam int N_ROW = N_PAR + N_RES,
  localparam int N_COL = N_IN + 1,
  localparam int SW    = $clog2(N_SET),
  localparam int RW    = $clog2(N_ROW),
  localparam int CLW   = $clog2(N_COL),
  localparam int CHW   = 2 * DW + $clog2(N_RES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SW-1:0]        in_set,
  input  logic [N_IN*DW-1:0]   in_coord,
  input  logic                 cfg_we,
  input  logic [SW-1:0]        cfg_set,
  input  logic [RW-1:0]        cfg_row,
  input  logic [CLW-1:0]       cfg_col,
  input  logic [CW-1:0]        cfg_data,
  output logic                 out_valid,
  output logic [DW-1:0]        out_curv,
  output logic [DW-1:0]        out_phi,
  output logic [DW-1:0]        out_d0,
  output logic [CHW-1:0]       out_chi2,
  output logic                 out_ovf
);
  localparam int LAT = N_ROW * N_IN;

  logic                 accept, busy, first_col, row_done, cand_done;
  logic [RW-1:0]        row_idx;
  logic [CLW-1:0]       col_idx;
  logic signed [DW-1:0] x_q [N_IN];
  logic [SW-1:0]        set_q;
  logic signed [DW-1:0] x_sel, res;
  logic                 res_clip;
  logic signed [CW-1:0] coef, offset;
  logic signed [DW-1:0] par_q [N_PAR];
  logic [CHW-1:0]       chi_acc, chi_next;
  logic                 ovf_acc;
  logic signed [2*DW-1:0] sq;

  assign accept   = in_valid && in_ready;
  assign in_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N_IN; j++) x_q[j] <= '0;
      set_q <= '0;
    end else if (accept) begin
      for (int j = 0; j < N_IN; j++) x_q[j] <= in_coord[j*DW +: DW];
      set_q <= in_set;
    end
  end

  always_comb begin
    x_sel = '0;
    for (int j = 0; j < N_IN; j++)
      if (col_idx == CLW'(j)) x_sel = x_q[j];
  end

  fit_sequencer #(.N_ROW(N_ROW), .N_IN(N_IN), .RW(RW), .CLW(CLW)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .busy(busy), .first_col(first_col),
    .row_done(row_done), .cand_done(cand_done), .row_idx(row_idx), .col_idx(col_idx)
  );

  fit_coef_store #(.N_SET(N_SET), .N_ROW(N_ROW), .N_COL(N_COL), .CW(CW),
                   .SW(SW), .RW(RW), .CLW(CLW)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_set(cfg_set), .wr_row(cfg_row),
    .wr_col(cfg_col), .wr_data(cfg_data), .rd_set(set_q), .rd_row(row_idx),
    .rd_col(col_idx), .rd_coef(coef), .rd_off(offset)
  );

  fit_mac #(.DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst(rst), .step(busy), .first(first_col), .x(x_sel),
    .coef(coef), .offset(offset), .res(res), .res_clip(res_clip)
  );

  assign sq       = res * res;
  assign chi_next = chi_acc + {{(CHW-2*DW){1'b0}}, sq};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_PAR; i++) par_q[i] <= '0;
      chi_acc   <= '0;
      ovf_acc   <= 1'b0;
      out_valid <= 1'b0;
      out_curv  <= '0;
      out_phi   <= '0;
      out_d0    <= '0;
      out_chi2  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      if (accept) begin
        chi_acc <= '0;
        ovf_acc <= 1'b0;
      end
      if (row_done) begin
        ovf_acc <= ovf_acc | res_clip;
        if (int'(row_idx) < N_PAR) begin
          for (int i = 0; i < N_PAR; i++)
            if (row_idx == RW'(i)) par_q[i] <= res;
        end else begin
          chi_acc <= chi_next;
        end
      end
      out_valid <= cand_done;
      if (cand_done) begin
        out_curv <= par_q[0];
        out_phi  <= par_q[1];
        out_d0   <= par_q[2];
        out_chi2 <= chi_next;
        out_ovf  <= ovf_acc | res_clip;
      end
    end
  end
endmodule

// File: rtl/fit_checker.sv
module fit_checker #(
  parameter int DW  = 16,
  parameter int CHW = 34,
  parameter int LAT = 36
) (
  input logic           clk,
  input logic           rst,
  input logic           accept,
  input logic           in_ready,
  input logic           out_valid,
  input logic [DW-1:0]  out_curv,
  input logic [DW-1:0]  out_phi,
  input logic [DW-1:0]  out_d0,
  input logic [CHW-1:0] out_chi2,
  input logic           out_ovf
);
  logic pend;
  int   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cnt  <= 0;
    end else if (accept) begin
      pend <= 1'b1;
      cnt  <= 0;
    end else if (pend) begin
      if (out_valid) pend <= 1'b0;
      else           cnt  <= cnt + 1;
    end
  end

  // R3
  strobe_at_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pend && cnt == LAT));

  // R3
  latency_reached_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && cnt == LAT) |-> out_valid);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R2
  ready_with_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  // R9
  results_held_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_curv) && $stable(out_phi) && $stable(out_d0)
                    && $stable(out_chi2) && $stable(out_ovf)));
endmodule

bind lin_track_fit fit_checker #(.DW(DW), .CHW(CHW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .in_ready(in_ready),
  .out_valid(out_valid), .out_curv(out_curv), .out_phi(out_phi),
  .out_d0(out_d0), .out_chi2(out_chi2), .out_ovf(out_ovf)
);

// File: tb/sim_lin_track_fit.sv
`timescale 1ns/1ps
module sim_lin_track_fit;
  localparam int N_IN = 6, N_RES = 3, N_SET = 4, DW = 16, CW = 18, FRAC = 8;
  localparam int N_ROW = 6, N_COL = 7, LAT = 36, CHW = 34;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_set = '0;
  logic [N_IN*DW-1:0] in_coord = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_set = '0;
  logic [2:0] cfg_row = '0, cfg_col = '0;
  logic [CW-1:0] cfg_data = '0;
  logic out_valid, out_ovf;
  logic [DW-1:0] out_curv, out_phi, out_d0;
  logic [CHW-1:0] out_chi2;

  always #10 clk = ~clk;

  lin_track_fit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_set(in_set), .in_coord(in_coord), .cfg_we(cfg_we), .cfg_set(cfg_set),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_curv(out_curv), .out_phi(out_phi),
    .out_d0(out_d0), .out_chi2(out_chi2), .out_ovf(out_ovf)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  longint m_mem [N_SET][N_ROW][N_COL];
  bit     m_busy, m_valid;
  int     m_cnt;
  longint e_par [3];
  longint e_chi;
  bit     e_ovf;
  longint p_par [3];
  longint p_chi;
  bit     p_ovf;
  longint t_acc, t_q;

  initial begin
    foreach (m_mem[s, r, c]) m_mem[s][r][c] = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_valid = 0; m_cnt = 0;
      e_par[0] = 0; e_par[1] = 0; e_par[2] = 0; e_chi = 0; e_ovf = 0;
      foreach (m_mem[s, r, c]) m_mem[s][r][c] = 0;
    end else begin
      if (cfg_we) m_mem[cfg_set][cfg_row][cfg_col] = longint'($signed(cfg_data));
      m_valid = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_valid = 1;
          e_par = p_par; e_chi = p_chi; e_ovf = p_ovf;
        end
      end else if (in_valid) begin
        p_chi = 0; p_ovf = 0;
        for (int r = 0; r < N_ROW; r++) begin
          t_acc = m_mem[in_set][r][N_IN];
          for (int j = 0; j < N_IN; j++)
            t_acc += m_mem[in_set][r][j] * longint'($signed(in_coord[j*DW +: DW]));
          t_q = t_acc >>> FRAC;
          if (t_q > 32767)  begin t_q = 32767;  p_ovf = 1; end
          if (t_q < -32768) begin t_q = -32768; p_ovf = 1; end
          if (r < 3) p_par[r] = t_q;
          else       p_chi += t_q * t_q;
        end
        m_busy = 1; m_cnt = LAT;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == m_valid, "R3 out_valid", longint'(out_valid), longint'(m_valid));
      chk(in_ready == !m_busy, "R2 in_ready", longint'(in_ready), longint'(!m_busy));
      chk(longint'($signed(out_curv)) == e_par[0], "R4/R9 out_curv", longint'($signed(out_curv)), e_par[0]);
      chk(longint'($signed(out_phi))  == e_par[1], "R4/R9 out_phi",  longint'($signed(out_phi)),  e_par[1]);
      chk(longint'($signed(out_d0))   == e_par[2], "R4/R9 out_d0",   longint'($signed(out_d0)),   e_par[2]);
      chk(longint'(out_chi2) == e_chi, "R5 out_chi2", longint'(out_chi2), e_chi);
      chk(out_ovf == e_ovf, "R6 out_ovf", longint'(out_ovf), longint'(e_ovf));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [N_IN*DW-1:0] pack6(input int a, b, c, d, e, f);
    return {DW'(f), DW'(e), DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  task automatic write_c(input int s, r, c, v);
    @(negedge clk);
    cfg_we = 1; cfg_set = 2'(s); cfg_row = 3'(r); cfg_col = 3'(c); cfg_data = CW'(v);
  endtask

  logic [DW-1:0] cap_curv;
  logic [CHW-1:0] cap_chi;

  task automatic wait_result();
    do @(negedge clk); while (!out_valid);
    cap_curv = out_curv; cap_chi = out_chi2;
  endtask

  // Offer a candidate; optionally keep in_valid high with junk while busy (R2)
  task automatic fit(input int s, input logic [N_IN*DW-1:0] v, input bit junk);
    do @(negedge clk); while (!in_ready);
    in_valid = 1; in_set = 2'(s); in_coord = v;
    @(negedge clk);
    if (junk) begin
      in_set = 2'(s ^ 1); in_coord = ~v;
      repeat (12) @(negedge clk);
    end
    in_valid = 0;
    wait_result();
  endtask

  logic [DW-1:0] keep_curv;
  logic [CHW-1:0] keep_chi;

  initial begin
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);
    chk(out_valid == 1'b0 && out_ovf == 1'b0, "R1 flags", longint'({out_valid, out_ovf}), 0);
    rst = 0;
    @(negedge clk);
    chk(out_curv == '0 && out_phi == '0 && out_d0 == '0 && out_chi2 == '0, "R1 results",
        longint'(out_curv), 0);

    // R8: load banks 0..2 with varied constants, bank 3 with huge ones
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < N_ROW; r++)
        for (int c = 0; c < N_COL; c++)
          write_c(s, r, c, (((s * 11 + r * 7 + c * 3) % 19) - 9) * (300 + 50 * s));
    for (int r = 0; r < N_ROW; r++)
      for (int c = 0; c < N_COL; c++)
        write_c(3, r, c, (r % 2 == 0) ? 100000 : -100000);
    @(negedge clk); cfg_we = 0;

    // R4/R5: several input patterns
    fit(0, pack6(0, 0, 0, 0, 0, 0), 0);
    fit(0, pack6(100, -200, 300, -400, 500, -600), 0);
    fit(1, pack6(32767, 32767, 32767, 32767, 32767, 32767), 0);
    fit(2, pack6(-32768, -32768, -32768, -32768, -32768, -32768), 0);
    fit(2, pack6(1234, -4321, 7, -8, 25000, -25000), 0);

    // R6: clipping in both directions
    fit(3, pack6(20000, 20000, 20000, 20000, 20000, 20000), 0);
    chk(out_ovf == 1'b1, "R6 ovf set", longint'(out_ovf), 1);
    fit(3, pack6(-20000, -20000, -20000, -20000, -20000, -20000), 0);
    fit(0, pack6(5, 6, 7, 8, 9, 10), 0);
    chk(out_ovf == 1'b0, "R6 ovf clear", longint'(out_ovf), 0);

    // R2: junk offered while busy is ignored
    fit(1, pack6(3000, -3000, 2000, -2000, 1000, -1000), 1);

    // R7: same coordinates, different banks
    fit(0, pack6(900, 800, -700, 600, -500, 400), 0);
    keep_curv = cap_curv; keep_chi = cap_chi;
    fit(1, pack6(900, 800, -700, 600, -500, 400), 0);
    chk(cap_curv != keep_curv || cap_chi != keep_chi, "R7 bank differs",
        longint'(cap_curv), longint'(keep_curv));

    // R8: rewrite one weight between candidates
    fit(0, pack6(4000, 0, 0, 0, 0, 0), 0);
    keep_curv = cap_curv;
    write_c(0, 0, 0, 2560);
    @(negedge clk); cfg_we = 0;
    fit(0, pack6(4000, 0, 0, 0, 0, 0), 0);
    chk(cap_curv != keep_curv, "R8 rewrite used", longint'(cap_curv), longint'(keep_curv));

    // R3: back-to-back candidates with in_valid held high
    do @(negedge clk); while (!in_ready);
    in_valid = 1; in_set = 2; in_coord = pack6(11, 22, 33, 44, 55, 66);
    repeat (LAT + 3) @(negedge clk);
    in_valid = 0;
    wait_result();
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule